// File: doc/BRIEF.md
# Dual-Channel UART Command and Status Block

This block holds the host-side control registers for the pair of serial channels that share one block of a larger multi-channel UART. An 8-bit register bus reaches it. When the upper address bits select this block, the block decodes a channel register offset. It can then run a command write, which can toggle the receiver and transmitter and carry one of several reset opcodes. It can also read or write the two-entry mode store through its self-advancing pointer, return the channel status, or pass a transmit byte onward. Serial bit timing sits in a neighbouring receiver and transmitter.

The receiver side supplies data-ready and FIFO-full levels, the byte at the head of its FIFO, and one-cycle error pulses. In return the block gives it a receive-enable level, a pop pulse on each holding-register read and a flush pulse on a receiver reset. Accepted transmit bytes appear one cycle after the write, as a valid pulse with the data. A shared 8-bit interrupt status word packs, for each channel, a transmit-ready bit, a receive-ready bit and a latched break bit.

Top module: `uart_blk_ctrl`

## Requirements
- R1: An access hits this block only when `bus_sel` is high and address bits 7:5 equal `BLK_ID`. The register offset is address bits 4:0 XOR 0x01, and offset bit 4 selects the channel (0 first, 1 second). An access that misses changes nothing and reads 0.
- R2: Within one command write (offset low nibble 0x5), bit 0 enables the receiver and bit 1 disables it. Bit 2 enables the transmitter and bit 3 disables it. The bits take effect in that order, so a disable in the same byte wins. `rx_en` shows each channel's receive enable.
- R3: Enabling the transmitter sets status bits 2 and 3 and the channel's transmit-ready interrupt bit (bit 0 for the first channel, bit 4 for the second). A transmitter disable clears all three, and so does opcode 3 in command bits 7:4.
- R4: Opcode 2 turns the receiver off and raises that channel's `rx_flush` during the writing cycle.
- R5: Opcode 4 clears status bits 7:4, which are break, framing, parity and overrun from high to low. Error pulses on `rx_err_set` set these bits (per channel: bit 0 overrun, 1 parity, 2 framing, 3 break). A pulse in the same cycle as the clear wins.
- R6: A break pulse also sets the channel's break interrupt bit (bit 2 or bit 6). Opcode 5 written to either channel clears both break interrupt bits. A break pulse in the same cycle wins.
- R7: Each read or write of the mode register (offset low nibble 0x1) uses the entry chosen by the pointer, and the pointer then becomes 1. Opcode 1 returns it to 0. Both the entries and the pointer reset to 0.
- R8: A write to the holding register (offset low nibble 0x7) produces a one-cycle `tx_valid` pulse for that channel, with the byte on `tx_data`, in the next cycle. This happens only if the transmitter was enabled before the write. Otherwise the byte is dropped.
- R9: A status read (low nibble 0x3) returns {error bits 7:4, tx enabled, tx enabled, `rx_full`, `rx_rdy`}. A read of offset 0x0B returns the interrupt status word: for channel k, bit 4k is tx enabled, bit 4k+1 is `rx_rdy`, bit 4k+2 is break latched and bit 4k+3 is 0.
- R10: A holding-register read returns that channel's `rx_byte` and raises its `rx_pop` during the cycle of the read.
- R11: Reads of offsets 0x09 and 0x1B, and reads with `bus_wr` high or `bus_sel` low, return 0. Writes to status (clock select), 0x09, 0x0B and 0x1B change nothing, and so do opcodes 0 and 6 to 15.
- R12: After reset the receiver and transmitter are off, all error and break state is clear, and `tx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid in the access cycle |
| rx_rdy | input | 2 | Receiver has data, per channel |
| rx_full | input | 2 | Receiver FIFO full, per channel |
| rx_byte | input | 2*DW | Head-of-FIFO byte, channel 0 in the low byte |
| rx_err_set | input | 8 | Error pulses, four per channel |
| rx_pop | output | 2 | Holding-register read pulse |
| rx_flush | output | 2 | Receiver reset pulse |
| rx_en | output | 2 | Receiver enabled |
| tx_valid | output | 2 | Transmit byte accepted pulse |
| tx_data | output | DW | Transmit byte |
| int_stat | output | 8 | Interrupt status word |

## Verification
The bench checks that a disable bit beats an enable bit in the same byte. A design that applied the bits in the wrong order would leave the receiver or transmitter running. It checks that the mode pointer sticks at the second entry and only a pointer reset sends it back. A wrong pointer would make repeated reads alternate or wrap. It checks that a break-interrupt reset written on one channel also clears the other channel's break bit, and that an error or break pulse arriving in the same cycle as its clear survives. It also sends writes to a foreign block, to the ignored registers and with unused opcodes, and reads back the affected state to show that none of it changed.

// File: rtl/uart_blk_pkg.sv
`timescale 1ns/1ps
package uart_blk_pkg;

    localparam int NCH     = 2;
    localparam int ERR_W   = 4;
    localparam int ISR_PER = 4;

    // low nibble of the register offset
    localparam logic [3:0] OFS_MODE = 4'h1;
    localparam logic [3:0] OFS_STAT = 4'h3;
    localparam logic [3:0] OFS_CMD  = 4'h5;
    localparam logic [3:0] OFS_HOLD = 4'h7;
    localparam logic [3:0] OFS_INT  = 4'hB;

    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_MPTR   = 4'd1,
        OP_RXRST  = 4'd2,
        OP_TXRST  = 4'd3,
        OP_ERRRST = 4'd4,
        OP_BRKRST = 4'd5
    } cmd_op_e;

    typedef struct packed {
        logic mr_rd;
        logic mr_wr;
        logic sr_rd;
        logic cr_wr;
        logic hold_rd;
        logic hold_wr;
    } chan_acc_t;

endpackage

// File: rtl/uart_blk_decode.sv
`timescale 1ns/1ps
module uart_blk_decode
    import uart_blk_pkg::*;
#(
    parameter int AW     = 8,
    parameter int BLK_ID = 0
) (
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [AW-1:0]         bus_addr,
    output chan_acc_t [NCH-1:0]   acc,
    output logic                  isr_rd
);
    localparam int BLK_W = AW - 5;

    logic       hit;
    logic [4:0] ofs;

    always_comb begin
        hit    = bus_sel && (bus_addr[AW-1:5] == BLK_W'(BLK_ID));
        ofs    = bus_addr[4:0] ^ 5'h01;
        isr_rd = hit && !bus_wr && !ofs[4] && (ofs[3:0] == OFS_INT);
    end

    for (genvar k = 0; k < NCH; k++) begin : g_acc
        logic me;
        always_comb begin
            me               = hit && (ofs[4] == 1'(k));
            acc[k].mr_rd     = me && !bus_wr && (ofs[3:0] == OFS_MODE);
            acc[k].mr_wr     = me &&  bus_wr && (ofs[3:0] == OFS_MODE);
            acc[k].sr_rd     = me && !bus_wr && (ofs[3:0] == OFS_STAT);
            acc[k].cr_wr     = me &&  bus_wr && (ofs[3:0] == OFS_CMD);
            acc[k].hold_rd   = me && !bus_wr && (ofs[3:0] == OFS_HOLD);
            acc[k].hold_wr   = me &&  bus_wr && (ofs[3:0] == OFS_HOLD);
        end
    end

endmodule

// File: rtl/uart_chan_regs.sv
`timescale 1ns/1ps
module uart_chan_regs
    import uart_blk_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  chan_acc_t     acc,
    input  logic [DW-1:0] wdata,
    input  logic [ERR_W-1:0] err_set,
    input  logic          brk_clr,
    input  logic          rx_rdy,
    input  logic          rx_full,
    output logic [7:0]    stat,
    output logic [DW-1:0] mode_out,
    output logic          tx_on,
    output logic          brk_int,
    output logic          rx_en,
    output logic          rx_flush,
    output logic          tx_fire
);
    typedef struct packed {
        logic [1:0][DW-1:0] mr;
        logic               ptr;
        logic               tx_on;
        logic               rx_en;
        logic [ERR_W-1:0]   err;
        logic               brk;
    } chan_st_t;

    chan_st_t st_d, st_q;
    cmd_op_e  op;

    always_comb begin
        st_d     = st_q;
        rx_flush = 1'b0;
        op       = cmd_op_e'(wdata[7:4]);

        if (acc.mr_wr) begin
            st_d.mr[st_q.ptr] = wdata;
        end
        if (acc.mr_wr || acc.mr_rd) begin
            st_d.ptr = 1'b1;
        end

        if (acc.cr_wr) begin
            if (wdata[0]) st_d.rx_en = 1'b1;
            if (wdata[1]) st_d.rx_en = 1'b0;
            if (wdata[2]) st_d.tx_on = 1'b1;
            if (wdata[3]) st_d.tx_on = 1'b0;
            case (op)
                OP_MPTR:   st_d.ptr = 1'b0;
                OP_RXRST: begin
                    st_d.rx_en = 1'b0;
                    rx_flush   = 1'b1;
                end
                OP_TXRST:  st_d.tx_on = 1'b0;
                OP_ERRRST: st_d.err   = '0;
                default: ;
            endcase
        end

        if (brk_clr) begin
            st_d.brk = 1'b0;
        end

        // late events win over same-cycle clears
        st_d.err = st_d.err | err_set;
        if (err_set[ERR_W-1]) begin
            st_d.brk = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        stat     = {st_q.err, st_q.tx_on, st_q.tx_on, rx_full, rx_rdy};
        mode_out = st_q.mr[st_q.ptr];
        tx_on    = st_q.tx_on;
        brk_int  = st_q.brk;
        rx_en    = st_q.rx_en;
        tx_fire  = acc.hold_wr && st_q.tx_on;
    end

endmodule

// File: rtl/uart_blk_ctrl.sv
`timescale 1ns/1ps
module uart_blk_ctrl
    import uart_blk_pkg::*;
#(
    parameter int AW     = 8,
    parameter int DW     = 8,
    parameter int BLK_ID = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_sel,
    input  logic                   bus_wr,
    input  logic [AW-1:0]          bus_addr,
    input  logic [DW-1:0]          bus_wdata,
    output logic [DW-1:0]          bus_rdata,
    input  logic [NCH-1:0]         rx_rdy,
    input  logic [NCH-1:0]         rx_full,
    input  logic [NCH*DW-1:0]      rx_byte,
    input  logic [NCH*ERR_W-1:0]   rx_err_set,
    output logic [NCH-1:0]         rx_pop,
    output logic [NCH-1:0]         rx_flush,
    output logic [NCH-1:0]         rx_en,
    output logic [NCH-1:0]         tx_valid,
    output logic [DW-1:0]          tx_data,
    output logic [NCH*ISR_PER-1:0] int_stat
);
    localparam int ISR_W = NCH * ISR_PER;

    chan_acc_t [NCH-1:0] acc;
    logic                isr_rd;
    logic                brk_clr;
    logic [NCH-1:0]      tx_on, brk_int, tx_fire;
    logic [7:0]          stat   [NCH];
    logic [DW-1:0]       mode_o [NCH];

    typedef struct packed {
        logic [NCH-1:0] valid;
        logic [DW-1:0]  data;
    } tx_st_t;

    tx_st_t tx_d, tx_q;

    uart_blk_decode #(.AW(AW), .BLK_ID(BLK_ID)) u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .acc      (acc),
        .isr_rd   (isr_rd)
    );

    always_comb begin
        brk_clr = 1'b0;
        for (int k = 0; k < NCH; k++) begin
            if (acc[k].cr_wr && (bus_wdata[7:4] == OP_BRKRST)) brk_clr = 1'b1;
        end
    end

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        uart_chan_regs #(.DW(DW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .acc      (acc[k]),
            .wdata    (bus_wdata),
            .err_set  (rx_err_set[k*ERR_W +: ERR_W]),
            .brk_clr  (brk_clr),
            .rx_rdy   (rx_rdy[k]),
            .rx_full  (rx_full[k]),
            .stat     (stat[k]),
            .mode_out (mode_o[k]),
            .tx_on    (tx_on[k]),
            .brk_int  (brk_int[k]),
            .rx_en    (rx_en[k]),
            .rx_flush (rx_flush[k]),
            .tx_fire  (tx_fire[k])
        );

        always_comb begin
            int_stat[k*ISR_PER +: ISR_PER] = {1'b0, brk_int[k], rx_rdy[k], tx_on[k]};
            rx_pop[k] = acc[k].hold_rd;
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NCH; k++) begin
            if (acc[k].mr_rd)   bus_rdata = mode_o[k];
            if (acc[k].sr_rd)   bus_rdata = DW'(stat[k]);
            if (acc[k].hold_rd) bus_rdata = rx_byte[k*DW +: DW];
        end
        if (isr_rd) bus_rdata = DW'(int_stat[ISR_W-1:0]);
    end

    always_comb begin
        tx_d       = tx_q;
        tx_d.valid = tx_fire;
        if (|tx_fire) tx_d.data = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign tx_valid = tx_q.valid;
    assign tx_data  = tx_q.data;

endmodule

// File: rtl/uart_blk_ctrl_chk.sv
`timescale 1ns/1ps
module uart_blk_ctrl_chk
    import uart_blk_pkg::*;
#(
    parameter int AW     = 8,
    parameter int DW     = 8,
    parameter int BLK_ID = 0
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_sel,
    input logic                   bus_wr,
    input logic [AW-1:0]          bus_addr,
    input logic [DW-1:0]          bus_wdata,
    input logic [DW-1:0]          bus_rdata,
    input logic [NCH*ERR_W-1:0]   rx_err_set,
    input logic [NCH-1:0]         rx_pop,
    input logic [NCH-1:0]         rx_flush,
    input logic [NCH-1:0]         rx_en,
    input logic [NCH-1:0]         tx_valid,
    input logic [NCH*ISR_PER-1:0] int_stat
);
    localparam int BLK_W = AW - 5;

    logic here, cmd0, hold_wr0, hold_rd0, any_cmd;
    always_comb begin
        here     = bus_sel && (bus_addr[AW-1:5] == BLK_W'(BLK_ID));
        cmd0     = here && bus_wr && (bus_addr[4:0] == 5'h04);
        any_cmd  = here && bus_wr && (bus_addr[3:0] == 4'h4);
        hold_wr0 = here && bus_wr && (bus_addr[4:0] == 5'h06);
        hold_rd0 = here && !bus_wr && (bus_addr[4:0] == 5'h06);
    end

    // R2
    rx_dis_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd0 && bus_wdata[1] |=> !rx_en[0]);

    // R3
    tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd0 && bus_wdata[3] |=> !int_stat[0]);

    // R8
    hold_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_wr0 && !int_stat[0] |=> !tx_valid[0]);

    // R6
    brk_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_cmd && (bus_wdata[7:4] == 4'd5) && !rx_err_set[3] && !rx_err_set[7]
        |=> !int_stat[2] && !int_stat[6]);

    // R1
    foreign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && !here && (rx_err_set == '0)
        |=> $stable(int_stat[0]) && $stable(int_stat[2]) && $stable(int_stat[4]) && $stable(int_stat[6]));

    // R4
    flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush[0] |-> cmd0);

    // R10
    pop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop[0] |-> hold_rd0);

    // R11
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> bus_rdata == '0);

endmodule

bind uart_blk_ctrl uart_blk_ctrl_chk #(.AW(AW), .DW(DW), .BLK_ID(BLK_ID)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .rx_err_set (rx_err_set),
    .rx_pop     (rx_pop),
    .rx_flush   (rx_flush),
    .rx_en      (rx_en),
    .tx_valid   (tx_valid),
    .int_stat   (int_stat)
);

// File: tb/uart_blk_ctrl_tb.sv
`timescale 1ns/1ps
module uart_blk_ctrl_tb;
    localparam int BLK = 5;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0, bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [1:0]  rx_rdy = '0, rx_full = '0;
    logic [15:0] rx_byte = '0;
    logic [7:0]  rx_err_set = '0;
    logic [1:0]  rx_pop, rx_flush, rx_en, tx_valid;
    logic [7:0]  tx_data, int_stat;

    always #2.5 clk = ~clk;

    uart_blk_ctrl #(.AW(8), .DW(8), .BLK_ID(BLK)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_rdy(rx_rdy), .rx_full(rx_full), .rx_byte(rx_byte),
        .rx_err_set(rx_err_set), .rx_pop(rx_pop), .rx_flush(rx_flush),
        .rx_en(rx_en), .tx_valid(tx_valid), .tx_data(tx_data), .int_stat(int_stat)
    );

    // expected state
    logic [7:0] m_mr [2][2];
    logic       m_ptr [2], m_tx [2], m_rx [2], m_brk [2];
    logic [3:0] m_err [2];

    int  n_chk = 0, n_fail = 0;
    bit  done = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] a_of(int ch, logic [3:0] o, int blk);
        return {3'(blk), 1'(ch), o ^ 4'h1};
    endfunction

    function automatic logic [7:0] exp_isr();
        return {1'b0, m_brk[1], rx_rdy[1], m_tx[1], 1'b0, m_brk[0], rx_rdy[0], m_tx[0]};
    endfunction

    task automatic do_acc(string tag, bit wr, logic [7:0] addr, logic [7:0] wd, logic [7:0] err);
        logic       hit;
        logic [4:0] ofs;
        int         ch;
        logic [3:0] o;
        logic [7:0] e_rd;
        logic [1:0] e_pop, e_flush, e_tx;
        string      kind;
        hit = (addr[7:5] == 3'(BLK));
        ofs = addr[4:0] ^ 5'h01;
        ch  = int'(ofs[4]);
        o   = ofs[3:0];
        e_rd = '0; e_pop = '0; e_flush = '0; e_tx = '0;
        kind = hit ? "R11" : "R1";
        if (hit && !wr) begin
            case (o)
                4'h1: begin e_rd = m_mr[ch][m_ptr[ch]]; kind = "R7"; end
                4'h3: begin e_rd = {m_err[ch], m_tx[ch], m_tx[ch], rx_full[ch], rx_rdy[ch]}; kind = "R9"; end
                4'h7: begin e_rd = rx_byte[ch*8 +: 8]; e_pop[ch] = 1'b1; kind = "R10"; end
                4'hB: if (!ofs[4]) begin e_rd = exp_isr(); kind = "R9"; end
                default: ;
            endcase
        end
        if (hit && wr && o == 4'h5 && wd[7:4] == 4'd2) e_flush[ch] = 1'b1;
        if (hit && wr && o == 4'h7 && m_tx[ch]) e_tx[ch] = 1'b1;

        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = addr; bus_wdata = wd; rx_err_set = err;
        #1;
        chk({tag, " ", kind, " rdata"}, 32'(bus_rdata), 32'(e_rd));
        chk({tag, " R10 pop"}, 32'(rx_pop), 32'(e_pop));
        chk({tag, " R4 flush"}, 32'(rx_flush), 32'(e_flush));

        // expected state after the edge
        if (hit) begin
            if (wr && o == 4'h1) m_mr[ch][m_ptr[ch]] = wd;
            if (o == 4'h1) m_ptr[ch] = 1'b1;
            if (wr && o == 4'h5) begin
                if (wd[0]) m_rx[ch] = 1'b1;
                if (wd[1]) m_rx[ch] = 1'b0;
                if (wd[2]) m_tx[ch] = 1'b1;
                if (wd[3]) m_tx[ch] = 1'b0;
                case (wd[7:4])
                    4'd1: m_ptr[ch] = 1'b0;
                    4'd2: m_rx[ch]  = 1'b0;
                    4'd3: m_tx[ch]  = 1'b0;
                    4'd4: m_err[ch] = '0;
                    4'd5: begin m_brk[0] = 1'b0; m_brk[1] = 1'b0; end
                    default: ;
                endcase
            end
        end
        for (int k = 0; k < 2; k++) begin
            m_err[k] = m_err[k] | err[k*4 +: 4];
            if (err[k*4+3]) m_brk[k] = 1'b1;
        end

        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0; rx_err_set = '0;
        chk({tag, " R8 tx_valid"}, 32'(tx_valid), 32'(e_tx));
        if (|e_tx) chk({tag, " R8 tx_data"}, 32'(tx_data), 32'(wd));
        chk({tag, " R3/R6 int_stat"}, 32'(int_stat), 32'(exp_isr()));
        chk({tag, " R2 rx_en"}, 32'({m_rx[1], m_rx[0]}), 32'(rx_en));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < 2; c++) begin
            m_mr[c][0] = '0; m_mr[c][1] = '0;
            m_ptr[c] = 0; m_tx[c] = 0; m_rx[c] = 0; m_brk[c] = 0; m_err[c] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        // R12 reset state
        chk("R12 int_stat", 32'(int_stat), 32'h0);
        chk("R12 rx_en", 32'(rx_en), 32'h0);
        chk("R12 tx_valid", 32'(tx_valid), 32'h0);
        chk("R12 rdata idle", 32'(bus_rdata), 32'h0);
        rst_n = 1'b1;
        do_acc("R12", 0, a_of(0, 4'h3, BLK), 8'h00, 8'h00);
        do_acc("R12", 0, a_of(1, 4'h1, BLK), 8'h00, 8'h00);

        // R7 mode pointer
        do_acc("R7", 1, a_of(0, 4'h1, BLK), 8'hA5, 8'h00);
        do_acc("R7", 1, a_of(0, 4'h1, BLK), 8'h3C, 8'h00);
        do_acc("R7", 1, a_of(0, 4'h1, BLK), 8'h77, 8'h00);
        do_acc("R7", 0, a_of(0, 4'h1, BLK), 8'h00, 8'h00);
        do_acc("R7", 1, a_of(0, 4'h5, BLK), 8'h10, 8'h00);
        do_acc("R7", 0, a_of(0, 4'h1, BLK), 8'h00, 8'h00);
        do_acc("R7", 0, a_of(0, 4'h1, BLK), 8'h00, 8'h00);

        // R2 / R3 enable, disable wins, transmitter reset
        do_acc("R2", 1, a_of(0, 4'h5, BLK), 8'h05, 8'h00);
        do_acc("R3", 0, a_of(0, 4'h3, BLK), 8'h00, 8'h00);
        do_acc("R2", 1, a_of(0, 4'h5, BLK), 8'h0F, 8'h00);
        do_acc("R3", 1, a_of(1, 4'h5, BLK), 8'h04, 8'h00);
        do_acc("R3", 1, a_of(1, 4'h5, BLK), 8'h30, 8'h00);

        // R8 holding gate
        do_acc("R8", 1, a_of(0, 4'h7, BLK), 8'h11, 8'h00);
        do_acc("R8", 1, a_of(0, 4'h5, BLK), 8'h04, 8'h00);
        do_acc("R8", 1, a_of(0, 4'h7, BLK), 8'h5A, 8'h00);

        // R5 error clear with a same-cycle overrun
        do_acc("R5", 1, a_of(1, 4'h9, BLK), 8'h00, 8'hF0);
        do_acc("R5", 1, a_of(1, 4'h5, BLK), 8'h40, 8'h10);
        do_acc("R5", 0, a_of(1, 4'h3, BLK), 8'h00, 8'h00);

        // R6 break clear from the other channel
        do_acc("R6", 1, a_of(0, 4'h9, BLK), 8'h00, 8'h08);
        do_acc("R6", 0, a_of(0, 4'hB, BLK), 8'h00, 8'h00);
        do_acc("R6", 1, a_of(1, 4'h5, BLK), 8'h50, 8'h00);
        do_acc("R6", 1, a_of(1, 4'h9, BLK), 8'h00, 8'h88);
        do_acc("R6", 1, a_of(0, 4'h5, BLK), 8'h50, 8'h80);

        // R4 receiver reset
        rx_rdy = 2'b01; rx_byte = 16'hC3_9E;
        do_acc("R4", 1, a_of(0, 4'h5, BLK), 8'h01, 8'h00);
        do_acc("R10", 0, a_of(0, 4'h7, BLK), 8'h00, 8'h00);
        do_acc("R4", 1, a_of(0, 4'h5, BLK), 8'h20, 8'h00);

        // R11 ignored writes, unused opcodes
        do_acc("R11", 1, a_of(0, 4'h3, BLK), 8'hFF, 8'h00);
        do_acc("R11", 1, a_of(0, 4'h9, BLK), 8'hFF, 8'h00);
        do_acc("R11", 1, a_of(0, 4'hB, BLK), 8'hFF, 8'h00);
        do_acc("R11", 1, a_of(1, 4'hB, BLK), 8'hFF, 8'h00);
        for (int op = 6; op < 16; op++) do_acc("R11", 1, a_of(0, 4'h5, BLK), 8'(op << 4), 8'h00);
        do_acc("R11", 0, a_of(0, 4'h9, BLK), 8'h00, 8'h00);
        do_acc("R11", 0, a_of(1, 4'hB, BLK), 8'h00, 8'h00);
        do_acc("R11", 0, a_of(0, 4'h3, BLK), 8'h00, 8'h00);

        // R1 foreign block
        do_acc("R1", 1, a_of(1, 4'h5, BLK ^ 1), 8'h0D, 8'h00);
        do_acc("R1", 1, a_of(0, 4'h5, BLK ^ 2), 8'h50, 8'h00);
        do_acc("R1", 0, a_of(0, 4'h3, BLK ^ 4), 8'h00, 8'h00);
        do_acc("R1", 0, a_of(1, 4'h3, BLK), 8'h00, 8'h00);

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] o;
            logic [7:0] wd, er;
            int         blk, ch;
            bit         wr;
            case ($urandom % 6)
                0: o = 4'h1;
                1: o = 4'h3;
                2: o = 4'h5;
                3: o = 4'h7;
                4: o = 4'h9;
                default: o = 4'hB;
            endcase
            ch  = int'($urandom % 2);
            blk = ($urandom % 10 == 0) ? int'($urandom % 8) : BLK;
            wr  = 1'($urandom);
            wd  = 8'($urandom);
            if (o == 4'h5) wd[7:4] = 4'($urandom % 8);
            er  = ($urandom % 6 == 0) ? 8'($urandom) : 8'h00;
            rx_rdy  = 2'($urandom);
            rx_full = 2'($urandom);
            rx_byte = 16'($urandom);
            do_acc("rand", wr, a_of(ch, o, blk), wd, er);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule